// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block decides, on every clock, which of the four switches of a full bridge are turned on: the upper and lower switch on side A and on side B. Its inputs are a direction bit, an enable used as the PWM chop, a decay select, a recirculation-path select, an active-low sleep request, an undervoltage-lockout release strobe and a disable from a protection block. Its outputs are four registered gate enables and a flag that shows when PWM input is being accepted.

While the enable is high, the direction bit picks the diagonal pair of switches that drives the motor. While the enable is low, the bridge recirculates. With fast decay, all switches are off and the current returns through the body diodes. With slow decay, both upper or both lower switches conduct, and this short across the motor also serves as the brake. Leaving sleep starts a wake timer whose length is a parameter in clock cycles. The default is one millisecond at 100 MHz. Until the timer expires, every gate stays off. Any change from one conducting pair to a different one passes through one clock with every gate off.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all four gate outputs and `wake_ready` are low.
- R2: After reset the block stays locked with all outputs low, whatever `sleep_n` does, until `uvlo_rel` is seen high at a clock edge. That release is latched until the next reset.
- R3: Once unlocked, `wake_ready` rises exactly `WAKE_CYCLES` clock edges after the first edge at which `sleep_n` is sampled high. While `wake_ready` is low, the gate outputs are low from the next edge onward.
- R4: If `sleep_n` is sampled low, all gates and `wake_ready` are low after that edge.
- R5: With `enable` high, `phase` high selects A-high plus B-low, and `phase` low selects B-high plus A-low.
- R6: With `enable` low and `mode1` low (fast decay), all four gates are off.
- R7: With `enable` low, `mode1` high and `mode2` high, A-high and B-high conduct. This is the high-side brake and it holds for as long as `enable` stays low.
- R8: With `enable` low, `mode1` high and `mode2` low, A-low and B-low conduct. `mode2` has no effect while `mode1` is low.
- R9: A change from one non-empty switch set to a different one shows exactly one cycle with all gates off before the new set appears. A change from all-off to a set takes effect at the next edge.
- R10: The upper and lower gate of the same side are never high together.
- R11: If `prot_off` is sampled high, all gates are off after that edge, whatever the other inputs are. `wake_ready` is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_rel | input | 1 | Undervoltage-lockout release strobe |
| sleep_n | input | 1 | Low requests sleep, high requests wake |
| prot_off | input | 1 | Protection disable, forces all gates off |
| phase | input | 1 | Drive direction |
| enable | input | 1 | PWM chop: high drives, low recirculates |
| mode1 | input | 1 | Decay select: high is slow, low is fast |
| mode2 | input | 1 | Slow-decay path: high uses the upper switches, low the lower ones |
| gate_a_hi | output | 1 | Side A upper switch enable |
| gate_a_lo | output | 1 | Side A lower switch enable |
| gate_b_hi | output | 1 | Side B upper switch enable |
| gate_b_lo | output | 1 | Side B lower switch enable |
| wake_ready | output | 1 | PWM input is accepted |

## Verification
The bench checks the wake timer on the exact edge before and after it expires. A timer that is off by one makes `wake_ready` or the first drive appear a cycle early or late. It reverses direction, moves from slow decay on one path to the other, and moves from braking back to drive, all of which must show a single all-off cycle. A design that switches straight across would short one side for that cycle, and one that idles too long shows a second empty cycle. It also drives `mode2` while `mode1` is low, sleeps and releases before the lockout strobe, and raises the protection disable during drive, expecting outputs that stay dark. A second reset must clear the latched lockout release.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic b_hi;
        logic b_lo;
    } gate_set_t;

    localparam gate_set_t GATES_OFF = '0;

    typedef enum logic [1:0] {
        DECAY_FAST    = 2'd0,
        DECAY_SLOW_HI = 2'd1,
        DECAY_SLOW_LO = 2'd2
    } decay_e;

    typedef enum logic [1:0] {
        WK_LOCKED = 2'd0,
        WK_ASLEEP = 2'd1,
        WK_WAKING = 2'd2,
        WK_READY  = 2'd3
    } wake_e;

    function automatic decay_e pick_decay(input logic slow, input logic upper_path);
        if (!slow)
            return DECAY_FAST;
        return upper_path ? DECAY_SLOW_HI : DECAY_SLOW_LO;
    endfunction

    function automatic gate_set_t drive_set(input logic dir);
        gate_set_t g;
        g = GATES_OFF;
        if (dir) begin
            g.a_hi = 1'b1;
            g.b_lo = 1'b1;
        end else begin
            g.b_hi = 1'b1;
            g.a_lo = 1'b1;
        end
        return g;
    endfunction

    function automatic gate_set_t recirc_set(input decay_e d);
        gate_set_t g;
        g = GATES_OFF;
        case (d)
            DECAY_SLOW_HI: begin
                g.a_hi = 1'b1;
                g.b_hi = 1'b1;
            end
            DECAY_SLOW_LO: begin
                g.a_lo = 1'b1;
                g.b_lo = 1'b1;
            end
            default: g = GATES_OFF;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hb_wake_timer.sv
module hb_wake_timer
    import hbridge_pkg::*;
#(
    parameter int WAKE_CYCLES = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic uvlo_rel,
    input  logic sleep_n,
    output logic ready
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYCLES - 1);

    wake_e            state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            WK_LOCKED: begin
                if (uvlo_rel)
                    state_d = WK_ASLEEP;
            end
            WK_ASLEEP: begin
                if (sleep_n) begin
                    cnt_d   = CNT_W'(1);
                    state_d = (WAKE_CYCLES <= 1) ? WK_READY : WK_WAKING;
                end
            end
            WK_WAKING: begin
                if (!sleep_n)
                    state_d = WK_ASLEEP;
                else if (cnt_q == LAST)
                    state_d = WK_READY;
                else
                    cnt_d = cnt_q + CNT_W'(1);
            end
            default: begin
                if (!sleep_n)
                    state_d = WK_ASLEEP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign ready = (state_q == WK_READY);

    AST_READY_NEEDS_AWAKE: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(sleep_n)); // R3
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == WK_LOCKED && !uvlo_rel) |=> (state_q == WK_LOCKED)); // R2
    AST_LOCK_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (state_q == WK_LOCKED) |-> !ready); // R2

endmodule

// File: rtl/hb_mode_decode.sv
module hb_mode_decode
    import hbridge_pkg::*;
(
    input  logic      allow,
    input  logic      phase,
    input  logic      enable,
    input  logic      mode1,
    input  logic      mode2,
    output gate_set_t target
);
    decay_e decay;

    always_comb begin
        decay = pick_decay(mode1, mode2);
        if (!allow)
            target = GATES_OFF;
        else if (enable)
            target = drive_set(phase);
        else
            target = recirc_set(decay);
    end

    always_comb begin
        if (allow && !enable && !mode1)
            AST_FAST_ALL_OFF: assert (target == GATES_OFF); // R6
        if (!allow)
            AST_BLOCKED_OFF: assert (target == GATES_OFF); // R11
    end

endmodule

// File: rtl/hb_dead_time.sv
module hb_dead_time
    import hbridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_set_t target,
    output gate_set_t gates
);
    gate_set_t gates_q, gates_d;

    always_comb begin
        if (target == gates_q)
            gates_d = gates_q;
        else if (gates_q == GATES_OFF)
            gates_d = target;
        else
            gates_d = GATES_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst)
            gates_q <= GATES_OFF;
        else
            gates_q <= gates_d;
    end

    assign gates = gates_q;

    logic [1:0] hi_bits, lo_bits;
    assign hi_bits = {gates_q.a_hi, gates_q.b_hi};
    assign lo_bits = {gates_q.a_lo, gates_q.b_lo};

    for (genvar s = 0; s < 2; s++) begin : g_side
        AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(hi_bits[s] && lo_bits[s])); // R10
    end

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        ($past(gates_q) != GATES_OFF && gates_q != $past(gates_q)) |-> (gates_q == GATES_OFF)); // R9

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbridge_pkg::*;
#(
    parameter int WAKE_CYCLES = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic uvlo_rel,
    input  logic sleep_n,
    input  logic prot_off,
    input  logic phase,
    input  logic enable,
    input  logic mode1,
    input  logic mode2,
    output logic gate_a_hi,
    output logic gate_a_lo,
    output logic gate_b_hi,
    output logic gate_b_lo,
    output logic wake_ready
);
    logic      ready;
    logic      allow;
    gate_set_t target;
    gate_set_t gates;

    hb_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .uvlo_rel (uvlo_rel),
        .sleep_n  (sleep_n),
        .ready    (ready)
    );

    assign allow = ready && sleep_n && !prot_off;

    hb_mode_decode u_decode (
        .allow  (allow),
        .phase  (phase),
        .enable (enable),
        .mode1  (mode1),
        .mode2  (mode2),
        .target (target)
    );

    hb_dead_time u_dead (
        .clk    (clk),
        .rst    (rst),
        .target (target),
        .gates  (gates)
    );

    assign gate_a_hi  = gates.a_hi;
    assign gate_a_lo  = gates.a_lo;
    assign gate_b_hi  = gates.b_hi;
    assign gate_b_lo  = gates.b_lo;
    assign wake_ready = ready;

    AST_PROT_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
        prot_off |=> (gates == GATES_OFF)); // R11
    AST_SLEEP_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (gates == GATES_OFF && !wake_ready)); // R4
    AST_WAKE_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        !wake_ready |=> (gates == GATES_OFF)); // R3

endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uvlo_rel = 1'b0, sleep_n = 1'b0, prot_off = 1'b0;
    logic phase = 1'b0, enable = 1'b0, mode1 = 1'b0, mode2 = 1'b0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, wake_ready;

    hbridge_gate_ctrl #(.WAKE_CYCLES(W)) u_hbridge_gate_ctrl (
        .clk(clk), .rst(rst), .uvlo_rel(uvlo_rel), .sleep_n(sleep_n),
        .prot_off(prot_off), .phase(phase), .enable(enable),
        .mode1(mode1), .mode2(mode2),
        .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
        .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo),
        .wake_ready(wake_ready)
    );

    always #5 clk = ~clk;

    // Expected word layout: {ready, a_hi, a_lo, b_hi, b_lo}
    localparam logic [4:0] OFF  = 5'b00000;
    localparam logic [4:0] RDY  = 5'b10000;
    localparam logic [4:0] FWD  = 5'b11001;
    localparam logic [4:0] REV  = 5'b10110;
    localparam logic [4:0] BRK_HI = 5'b11010;
    localparam logic [4:0] BRK_LO = 5'b10101;

    typedef struct {
        int         due;
        logic [4:0] exp;
        string      req;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Monitor: samples 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        cyc++;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [4:0] act;
            it = sb.pop_front();
            act = {wake_ready, gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s cycle %0d: actual %b expected %b", it.req, cyc, act, it.exp);
            end
            tests++;
            if ((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo)) begin
                fails++;
                $display("FAIL R10 cycle %0d: actual %b expected no same-side pair", cyc, act);
            end
        end
    end

    task automatic expect_at(input int n, input logic [4:0] e, input string r);
        item_t it;
        it.due = cyc + n;
        it.exp = e;
        it.req = r;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200_000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        expect_at(1, OFF, "R1");
        step(2);

        // Locked: sleep released, drive requested, no lockout release yet
        sleep_n = 1'b1; enable = 1'b1; phase = 1'b1;
        expect_at(1, OFF, "R2");
        expect_at(W + 3, OFF, "R2");
        step(W + 4);

        // Lockout release strobe, then wake count
        uvlo_rel = 1'b1;
        expect_at(W, OFF, "R3");
        expect_at(W + 1, RDY, "R3");
        expect_at(W + 2, FWD, "R5");
        step(1);
        uvlo_rel = 1'b0;
        step(W + 3);

        // Reverse direction: one dead cycle
        phase = 1'b0;
        expect_at(1, RDY, "R9");
        expect_at(2, REV, "R5");
        step(3);

        // Fast decay
        enable = 1'b0; mode1 = 1'b0;
        expect_at(1, RDY, "R6");
        step(2);
        mode2 = 1'b1;
        expect_at(1, RDY, "R8");
        expect_at(2, RDY, "R8");
        step(3);

        // Slow decay, high side: from all-off directly
        mode1 = 1'b1;
        expect_at(1, BRK_HI, "R7");
        expect_at(4, BRK_HI, "R7");
        step(5);

        // Switch to low-side path
        mode2 = 1'b0;
        expect_at(1, RDY, "R9");
        expect_at(2, BRK_LO, "R8");
        step(3);

        // Brake back to drive
        enable = 1'b1; phase = 1'b1;
        expect_at(1, RDY, "R9");
        expect_at(2, FWD, "R5");
        step(3);

        // Protection disable
        prot_off = 1'b1;
        expect_at(1, RDY, "R11");
        expect_at(3, RDY, "R11");
        step(4);
        prot_off = 1'b0;
        expect_at(1, FWD, "R9");
        step(2);

        // Sleep and wake again
        sleep_n = 1'b0;
        expect_at(1, OFF, "R4");
        step(3);
        sleep_n = 1'b1;
        expect_at(W - 1, OFF, "R3");
        expect_at(W, RDY, "R3");
        expect_at(W + 1, FWD, "R3");
        step(W + 2);

        // Second reset clears the latched release
        rst = 1'b1;
        expect_at(1, OFF, "R1");
        step(2);
        rst = 1'b0;
        expect_at(1, OFF, "R1");
        expect_at(W + 3, OFF, "R2");
        step(W + 5);

        finish_run();
    end

endmodule